// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block keeps a ring of receive buffer descriptors in a small internal store and fills them in as frames arrive. Each descriptor carries an empty flag, a wrap flag, a last-in-frame flag, an error flag and a byte length. A frame arrives as a stream of byte strobes marked with start, end and error qualifiers. The block claims the current descriptor at the start of a frame only if that descriptor is empty. It counts the bytes, including the trailing 4-byte check sequence. At the end of the frame it writes back the length and flags, clears the empty flag and steps to the next slot.

The ring is closed by the wrap flag rather than by a fixed depth. After reset only the highest slot carries it. Software may set it on an earlier slot to shorten the ring. When the engine meets a descriptor that software has not yet returned, it raises a stall indication and drops traffic. Software returns a descriptor by rewriting it as empty through a shared register port, and that also re-arms the stalled engine. A one-cycle done pulse marks every closed descriptor. A companion flag tells whether the frame passes the acceptance rule: last set, no error, and more than 14 bytes left once the 4-byte check sequence is removed.

Top module: `rxdesc_ring`

## Requirements
- R1: After reset every descriptor reads empty=1, last=0, err=0, length 0, with wrap=1 only on the highest slot; ringIdx is 0 and stall, rxDone and rxGood are 0.
- R2: A frame that starts on an empty descriptor is written back when its end byte arrives: length is the number of byte strobes from start to end inclusive, last=1, empty=0, and the wrap flag keeps its value.
- R3: ringIdx changes only when a descriptor is written back. It then goes to 0 if the written slot has wrap=1 or is the highest slot, and otherwise to the next index.
- R4: A frame longer than 1518 bytes is written back with err=1 and a length of 1518.
- R5: An error qualifier on any byte of an accepted frame sets err=1 in the written descriptor.
- R6: rxDone is 1 for exactly the cycle after each write-back. rxGood is 1 in that same cycle only if err=0 and the length is above 18.
- R7: A start byte that finds the current descriptor not empty sets stall from the next cycle. The whole frame is then dropped, with no rxDone, no descriptor change and no index change.
- R8: A software write that makes the current descriptor empty clears stall one cycle later. The rest of a frame already being dropped stays dropped, and the next frame is accepted.
- R9: A software write (swWrEn with swIdx) sets empty and wrap from swEmpty and swWrap and clears length, last and err.
- R10: If a software write and a hardware write-back hit the same slot in the same cycle, the write-back wins and the software write has no effect.
- R11: Byte strobes that do not belong to an accepted or dropped frame (no start seen) are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | One received byte this cycle |
| rxSof | input | 1 | Byte is the first of a frame |
| rxEof | input | 1 | Byte is the last of a frame |
| rxErr | input | 1 | Byte carries a receive error |
| swWrEn | input | 1 | Software descriptor write |
| swIdx | input | 3 | Descriptor selected for software read and write |
| swEmpty | input | 1 | Empty flag value to write |
| swWrap | input | 1 | Wrap flag value to write |
| swRdEmpty | output | 1 | Empty flag of selected descriptor |
| swRdWrap | output | 1 | Wrap flag of selected descriptor |
| swRdLast | output | 1 | Last flag of selected descriptor |
| swRdErr | output | 1 | Error flag of selected descriptor |
| swRdLen | output | 11 | Length of selected descriptor |
| ringIdx | output | 3 | Current ring position |
| stall | output | 1 | Engine waiting for a returned descriptor |
| rxDone | output | 1 | One-cycle pulse per written descriptor |
| rxGood | output | 1 | Written frame passes the acceptance rule |

## Verification
Directed frames probe the edges of the acceptance rule: an 18-byte frame is rejected and a 19-byte frame accepted, a single-byte frame opens and closes in one cycle, and a 1519-byte frame separates saturation from plain counting. A wrap flag set on slot 0 shows whether the index follows the flag or a fixed depth. A descriptor freed in the middle of a dropped frame shows whether the engine re-arms without accepting the tail. A write-back on the same cycle as a software write shows which side wins. Random frame lengths, errors, and random returns of descriptors are then checked against a ring model in the bench. This mix covers full-ring stalls, recovery, and long sequences of index wrap.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  // Ring configuration shared by all modules of the block
  parameter int RING_DEPTH = 8;
  parameter int FRAME_MAX  = 1518;
  parameter int FCS_BYTES  = 4;
  parameter int HDR_BYTES  = 14;

  localparam int IDX_W    = $clog2(RING_DEPTH);
  localparam int LEN_W    = $clog2(FRAME_MAX + 2);
  localparam int GOOD_MIN = FCS_BYTES + HDR_BYTES;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_TAKE = 2'd1,
    RX_DROP = 2'd2
  } rxState_e;

  typedef struct packed {
    logic             empty;
    logic             wrap;
    logic             last;
    logic             err;
    logic [LEN_W-1:0] len;
  } descEntry_t;

  // Strobes from control to the descriptor store
  typedef struct packed {
    logic             wbEn;
    logic [IDX_W-1:0] wbIdx;
    logic [LEN_W-1:0] wbLen;
    logic             wbErr;
  } wbStrobe_t;
endpackage

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxring_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic             rxSof,
  input  logic             rxEof,
  input  logic             rxErr,
  input  logic             curEmpty,
  input  logic             curWrap,
  output logic [IDX_W-1:0] ringIdx,
  output logic             stall,
  output logic             rxDone,
  output logic             rxGood,
  output wbStrobe_t        wb
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_DEPTH - 1);
  localparam logic [LEN_W-1:0] MAX_LEN  = LEN_W'(FRAME_MAX);
  localparam logic [LEN_W-1:0] MIN_GOOD = LEN_W'(GOOD_MIN);

  rxState_e         stateQ, nextState;
  logic [IDX_W-1:0] idxQ, nextIdx;
  logic [LEN_W-1:0] cntQ, nextCnt, cntInc;
  logic             errQ, nextErr;
  logic             stallQ, setStall;
  logic             doneQ, goodQ, goodNext;

  // Count saturates one above the limit so overflow stays visible
  assign cntInc = (cntQ > MAX_LEN) ? cntQ : cntQ + LEN_W'(1);

  always_comb begin
    wb        = '0;
    wb.wbIdx  = idxQ;
    nextState = stateQ;
    nextCnt   = cntQ;
    nextErr   = errQ;
    setStall  = 1'b0;
    if (rxValid) begin
      if (rxSof) begin
        if (curEmpty) begin
          if (rxEof) begin
            wb.wbEn   = 1'b1;
            wb.wbLen  = LEN_W'(1);
            wb.wbErr  = rxErr;
            nextState = RX_IDLE;
          end else begin
            nextState = RX_TAKE;
            nextCnt   = LEN_W'(1);
            nextErr   = rxErr;
          end
        end else begin
          setStall  = 1'b1;
          nextState = rxEof ? RX_IDLE : RX_DROP;
        end
      end else if (stateQ == RX_TAKE) begin
        if (rxEof) begin
          wb.wbEn   = 1'b1;
          wb.wbLen  = (cntInc > MAX_LEN) ? MAX_LEN : cntInc;
          wb.wbErr  = errQ | rxErr | (cntInc > MAX_LEN);
          nextState = RX_IDLE;
        end else begin
          nextCnt = cntInc;
          nextErr = errQ | rxErr;
        end
      end else if (stateQ == RX_DROP && rxEof) begin
        nextState = RX_IDLE;
      end
    end
  end

  assign nextIdx  = (curWrap || idxQ == LAST_IDX) ? '0 : idxQ + IDX_W'(1);
  assign goodNext = wb.wbEn && !wb.wbErr && (wb.wbLen > MIN_GOOD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= RX_IDLE;
      idxQ   <= '0;
      cntQ   <= '0;
      errQ   <= 1'b0;
      stallQ <= 1'b0;
      doneQ  <= 1'b0;
      goodQ  <= 1'b0;
    end else begin
      stateQ <= nextState;
      cntQ   <= nextCnt;
      errQ   <= nextErr;
      doneQ  <= wb.wbEn;
      goodQ  <= goodNext;
      if (wb.wbEn) idxQ <= nextIdx;
      if (setStall) stallQ <= 1'b1;
      else if (stallQ && curEmpty) stallQ <= 1'b0;
    end
  end

  assign ringIdx = idxQ;
  assign stall   = stallQ;
  assign rxDone  = doneQ;
  assign rxGood  = goodQ;

  AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stallQ) |-> $past(rxValid && rxSof && !curEmpty)); // R7
  AST_IDX_MOVES_ON_WB: assert property (@(posedge clk) disable iff (!rstN)
    (idxQ != $past(idxQ)) |-> $past(wb.wbEn)); // R3
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (wb.wbEn && curWrap) |=> (idxQ == '0)); // R3
  AST_GOOD_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    goodQ |-> doneQ); // R6
endmodule

// File: rtl/rxring_dpath.sv
module rxring_dpath
  import rxring_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  wbStrobe_t        wb,
  input  logic [IDX_W-1:0] curIdx,
  input  logic             swWrEn,
  input  logic [IDX_W-1:0] swIdx,
  input  logic             swEmpty,
  input  logic             swWrap,
  output logic             curEmpty,
  output logic             curWrap,
  output descEntry_t       swRd
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(FRAME_MAX);

  descEntry_t descQ [RING_DEPTH];

  for (genvar g = 0; g < RING_DEPTH; g++) begin : gSlot
    descEntry_t slotQ;
    logic       hwHit, swHit;
    assign hwHit = wb.wbEn && (wb.wbIdx == IDX_W'(g));
    assign swHit = swWrEn && (swIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotQ.empty <= 1'b1;
        slotQ.wrap  <= (g == RING_DEPTH - 1);
        slotQ.last  <= 1'b0;
        slotQ.err   <= 1'b0;
        slotQ.len   <= '0;
      end else if (hwHit) begin
        // hardware write-back has priority over software
        slotQ.empty <= 1'b0;
        slotQ.last  <= 1'b1;
        slotQ.err   <= wb.wbErr;
        slotQ.len   <= wb.wbLen;
      end else if (swHit) begin
        slotQ.empty <= swEmpty;
        slotQ.wrap  <= swWrap;
        slotQ.last  <= 1'b0;
        slotQ.err   <= 1'b0;
        slotQ.len   <= '0;
      end
    end
    assign descQ[g] = slotQ;
  end

  assign curEmpty = descQ[curIdx].empty;
  assign curWrap  = descQ[curIdx].wrap;
  assign swRd     = descQ[swIdx];

  AST_WB_WINS: assert property (@(posedge clk) disable iff (!rstN)
    wb.wbEn |=> (!descQ[$past(wb.wbIdx)].empty && descQ[$past(wb.wbIdx)].last)); // R10
  AST_SW_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (swWrEn && !(wb.wbEn && wb.wbIdx == swIdx)) |=> (descQ[$past(swIdx)].len == '0)); // R9
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rstN)
    wb.wbEn |-> (wb.wbLen <= MAX_LEN && wb.wbLen != '0)); // R4
endmodule

// File: rtl/rxdesc_ring.sv
module rxdesc_ring
  import rxring_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic             rxSof,
  input  logic             rxEof,
  input  logic             rxErr,
  input  logic             swWrEn,
  input  logic [IDX_W-1:0] swIdx,
  input  logic             swEmpty,
  input  logic             swWrap,
  output logic             swRdEmpty,
  output logic             swRdWrap,
  output logic             swRdLast,
  output logic             swRdErr,
  output logic [LEN_W-1:0] swRdLen,
  output logic [IDX_W-1:0] ringIdx,
  output logic             stall,
  output logic             rxDone,
  output logic             rxGood
);
  wbStrobe_t  wb;
  descEntry_t swRd;
  logic       curEmpty, curWrap;

  rxring_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .rxValid(rxValid), .rxSof(rxSof), .rxEof(rxEof), .rxErr(rxErr),
    .curEmpty(curEmpty), .curWrap(curWrap),
    .ringIdx(ringIdx), .stall(stall), .rxDone(rxDone), .rxGood(rxGood),
    .wb(wb)
  );

  rxring_dpath uDpath (
    .clk(clk), .rstN(rstN), .wb(wb), .curIdx(ringIdx),
    .swWrEn(swWrEn), .swIdx(swIdx), .swEmpty(swEmpty), .swWrap(swWrap),
    .curEmpty(curEmpty), .curWrap(curWrap), .swRd(swRd)
  );

  assign swRdEmpty = swRd.empty;
  assign swRdWrap  = swRd.wrap;
  assign swRdLast  = swRd.last;
  assign swRdErr   = swRd.err;
  assign swRdLen   = swRd.len;
endmodule

// File: tb/sim_rxdesc_ring.sv
`timescale 1ns/1ps
module sim_rxdesc_ring;
  localparam int N   = 8;
  localparam int MAX = 1518;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxValid = 0, rxSof = 0, rxEof = 0, rxErr = 0;
  logic swWrEn = 0, swEmpty = 0, swWrap = 0;
  logic [2:0] swIdx = '0;
  logic swRdEmpty, swRdWrap, swRdLast, swRdErr;
  logic [10:0] swRdLen;
  logic [2:0] ringIdx;
  logic stall, rxDone, rxGood;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  bit mEmpty [N];
  bit mWrap  [N];
  bit mLast  [N];
  bit mErr   [N];
  int mLen   [N];
  int mIdx;

  always #2.5 clk = ~clk;

  rxdesc_ring u0 (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxSof(rxSof), .rxEof(rxEof), .rxErr(rxErr),
    .swWrEn(swWrEn), .swIdx(swIdx), .swEmpty(swEmpty), .swWrap(swWrap),
    .swRdEmpty(swRdEmpty), .swRdWrap(swRdWrap), .swRdLast(swRdLast), .swRdErr(swRdErr),
    .swRdLen(swRdLen), .ringIdx(ringIdx), .stall(stall), .rxDone(rxDone), .rxGood(rxGood)
  );

  function automatic bit expGood(int len, bit err);
    return !err && (len > 18);
  endfunction

  function automatic int expNext(int idx);
    return (mWrap[idx] || idx == N - 1) ? 0 : idx + 1;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelInit();
    for (int i = 0; i < N; i++) begin
      mEmpty[i] = 1; mWrap[i] = (i == N - 1); mLast[i] = 0; mErr[i] = 0; mLen[i] = 0;
    end
    mIdx = 0;
  endtask

  task automatic doReset();
    rstN = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    modelInit();
  endtask

  task automatic pushByte(bit s, bit e, bit r);
    rxValid = 1; rxSof = s; rxEof = e; rxErr = r;
    @(posedge clk);
    #1;
    rxValid = 0; rxSof = 0; rxEof = 0; rxErr = 0;
  endtask

  task automatic swWrite(int idx, bit emp, bit wr);
    swWrEn = 1; swIdx = 3'(idx); swEmpty = emp; swWrap = wr;
    @(posedge clk);
    #1 swWrEn = 0;
    mEmpty[idx] = emp; mWrap[idx] = wr; mLast[idx] = 0; mErr[idx] = 0; mLen[idx] = 0;
  endtask

  task automatic checkDesc(int idx, string tag);
    swIdx = 3'(idx);
    #0.5;
    chk(swRdEmpty == mEmpty[idx], {tag, " empty"}, swRdEmpty, mEmpty[idx]);
    chk(swRdWrap == mWrap[idx], {tag, " wrap"}, swRdWrap, mWrap[idx]);
    chk(swRdLast == mLast[idx], {tag, " last"}, swRdLast, mLast[idx]);
    chk(swRdErr == mErr[idx], {tag, " err"}, swRdErr, mErr[idx]);
    chk(int'(swRdLen) == mLen[idx], {tag, " len"}, swRdLen, mLen[idx]);
  endtask

  // Sends one frame and checks it against the ring model
  task automatic runFrame(int len, int errAt, string tag);
    bit accept, err;
    int slot, expLen;
    slot   = mIdx;
    accept = mEmpty[slot];
    err    = (errAt >= 0) || (len > MAX);
    expLen = (len > MAX) ? MAX : len;
    for (int b = 0; b < len; b++) pushByte(b == 0, b == len - 1, b == errAt);
    if (accept) begin
      mEmpty[slot] = 0; mLast[slot] = 1; mErr[slot] = err; mLen[slot] = expLen;
      mIdx = expNext(slot);
      chk(rxDone == 1, {tag, " R6 done"}, rxDone, 1);
      chk(rxGood == expGood(expLen, err), {tag, " R6 good"}, rxGood, expGood(expLen, err));
    end else begin
      chk(rxDone == 0, {tag, " R7 no done"}, rxDone, 0);
      chk(stall == 1, {tag, " R7 stall"}, stall, 1);
    end
    chk(int'(ringIdx) == mIdx, {tag, " R3 idx"}, ringIdx, mIdx);
    checkDesc(slot, {tag, " R2 desc"});
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    doReset();
    // R1 reset state
    for (int i = 0; i < N; i++) checkDesc(i, "R1 reset");
    chk(ringIdx == 0, "R1 idx", ringIdx, 0);
    chk(stall == 0, "R1 stall", stall, 0);
    chk(rxDone == 0 && rxGood == 0, "R1 done", rxDone, 0);

    // R11 stray bytes without a start
    pushByte(0, 0, 0); pushByte(0, 0, 1); pushByte(0, 1, 0);
    chk(rxDone == 0, "R11 no done", rxDone, 0);
    chk(ringIdx == 0, "R11 idx", ringIdx, 0);
    checkDesc(0, "R11 desc");

    runFrame(64, -1, "R2 f64");
    runFrame(18, -1, "R6 f18");
    runFrame(19, -1, "R6 f19");
    runFrame(30, 10, "R5 errbyte");
    runFrame(1, -1, "R2 single");
    runFrame(1519, -1, "R4 long");

    // R9 software rewrite of slot 0 with wrap set
    swWrite(0, 1, 1);
    checkDesc(0, "R9 rewrite");
    runFrame(20, -1, "R3 s6");
    runFrame(21, -1, "R3 s7");
    runFrame(22, -1, "R3 wrap0");
    chk(ringIdx == 0, "R3 early wrap", ringIdx, 0);

    // R7 full ring stalls
    runFrame(10, -1, "R7 drop");

    // R8 free the slot in the middle of a dropped frame
    pushByte(1, 0, 0);
    for (int b = 0; b < 4; b++) pushByte(0, 0, 0);
    swWrite(0, 1, 0);
    pushByte(0, 0, 0);
    chk(stall == 0, "R8 stall cleared", stall, 0);
    pushByte(0, 1, 0);
    chk(rxDone == 0, "R8 tail dropped", rxDone, 0);
    checkDesc(0, "R8 slot untouched");
    runFrame(40, -1, "R8 resume");

    // R10 collision of software write and write-back
    swWrite(1, 1, 0);
    for (int b = 0; b < 24; b++) pushByte(b == 0, 0, 0);
    swWrEn = 1; swIdx = 3'd1; swEmpty = 1; swWrap = 1;
    pushByte(0, 1, 0);
    swWrEn = 0;
    mEmpty[1] = 0; mLast[1] = 1; mErr[1] = 0; mLen[1] = 25; mIdx = 2;
    checkDesc(1, "R10 hw wins");
    chk(rxDone == 1, "R10 done", rxDone, 1);

    // Random phase against the ring model
    doReset();
    for (int k = 0; k < 80; k++) begin
      int len, errAt;
      bit wasFull;
      len = 1 + int'($urandom % 90);
      errAt = ($urandom % 6 == 0) ? int'($urandom % len) : -1;
      wasFull = !mEmpty[mIdx];
      runFrame(len, errAt, "R2 random");
      if (wasFull) begin
        swWrite(mIdx, 1, mWrap[mIdx]);
        @(posedge clk); #1;
        chk(stall == 0, "R8 random rearm", stall, 0);
      end
      if ($urandom % 2 == 0) begin
        int f;
        f = int'($urandom % N);
        swWrite(f, 1, mWrap[f]);
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule